// File: doc/BRIEF.md
# Flash Block Write-Protection Gate

This block keeps the write-protection level of every block of a flash array. It decides, for each access that arrives, whether the access may be passed on to the array. Each block sits at one of three levels: open, locked or pinned. Protection commands on a small command port move a block between these levels. A separate input reports that the programming supply has dropped below its safe threshold. While that input is high, nothing may modify the array.

Program and erase accesses are forwarded only when their target block is open and the supply is good. Reads are always forwarded. A refused access never reaches the array. It raises a sticky error flag, which stays set until a clear command. A read-back port shows the current level of any block, so software can inspect the protection map.

Every block starts locked after reset. A protection command takes effect for a request in the same cycle, so no request can slip through on a stale level.

Top module: `lockprot_unit`

## Requirements
- R1: After reset every block reads back as locked (code 01), `err_locked` is low and no response is issued.
- R2: `rd_state` shows the level of block `rd_blk` as 00 open, 01 locked or 11 pinned. The code 10 never appears.
- R3: A command with `cmd_op` 01 locks block `cmd_blk` and 10 opens it. The new level is visible on `rd_state` right after the clock edge that takes the command.
- R4: A request in the same cycle as a command to the same block is judged on the level that command produces.
- R5: A modifying request is granted only if its block is open. A locked or pinned block denies it. `req_op` 01 (program), 10 (erase) and 11 all count as modifying. The verdict appears on `resp_valid`, `resp_grant` and `resp_deny` one cycle after the request.
- R6: While `supply_low` is high, every modifying request is denied, whatever the block's level.
- R7: A read (`req_op` 00) is always granted, regardless of the block's level or of `supply_low`.
- R8: `cmd_op` 11 pins a block, starting from either open or locked. A pinned block ignores open and lock commands and leaves the pinned level only on reset.
- R9: A denied request sets the sticky `err_locked`. A command with `cmd_op` 00 clears it. If a denial and a clear fall in the same cycle, the flag ends up set.
- R10: A granted request appears on `array_valid`, `array_op` and `array_blk` together with its verdict. A denied request leaves `array_valid` low.
- R11: A command changes only the block it addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Protection command present |
| cmd_op | input | 2 | 00 clear error, 01 lock, 10 open, 11 pin |
| cmd_blk | input | BW | Block addressed by the command |
| req_valid | input | 1 | Access request present |
| req_op | input | 2 | 00 read, 01 program, 10 erase, 11 other modifying |
| req_blk | input | BW | Block addressed by the request |
| supply_low | input | 1 | Programming supply below lockout threshold |
| rd_blk | input | BW | Block whose level is read back |
| rd_state | output | 2 | Level of `rd_blk` |
| resp_valid | output | 1 | Verdict for the previous cycle's request |
| resp_grant | output | 1 | Request was granted |
| resp_deny | output | 1 | Request was refused |
| array_valid | output | 1 | Granted access forwarded to the array |
| array_op | output | 2 | Operation of the forwarded access |
| array_blk | output | BW | Block of the forwarded access |
| err_locked | output | 1 | Sticky protection-error flag |

## Verification
The bench places a lock or open command in the same cycle as a request to the same block. A design without the same-cycle bypass would grant an erase to a block that was just locked, or deny one that was just opened. It sends open and lock commands to a pinned block and reads back the level. A design that let a pinned block fall back would show 00 or 01 and grant a later erase. It raises `supply_low` against an open block and against a read, to catch a design that ignores the lockout or wrongly extends it to reads. It also fires a denial and an error clear in the same cycle, where a design with the wrong priority would leave the flag low.

// File: rtl/lockprot_pkg.sv
package lockprot_pkg;

    // Per-block protection level, two bits per block
    typedef enum logic [1:0] {
        PL_OPEN   = 2'b00,
        PL_LOCKED = 2'b01,
        PL_PINNED = 2'b11
    } prot_lvl_e;

    // Protection command codes
    typedef enum logic [1:0] {
        CMD_CLR_ERR = 2'b00,
        CMD_LOCK    = 2'b01,
        CMD_OPEN    = 2'b10,
        CMD_PIN     = 2'b11
    } cmd_op_e;

    // Access request codes
    typedef enum logic [1:0] {
        ACC_READ  = 2'b00,
        ACC_PROG  = 2'b01,
        ACC_ERASE = 2'b10,
        ACC_OTHER = 2'b11
    } acc_op_e;

    // Registered verdict carried to the outputs
    typedef struct packed {
        logic    valid;
        logic    grant;
        acc_op_e op;
    } verdict_t;

    // Level a block moves to when it receives a command
    function automatic prot_lvl_e lvl_next(prot_lvl_e cur, cmd_op_e op);
        prot_lvl_e nxt;
        nxt = cur;
        if (op == CMD_PIN) begin
            nxt = PL_PINNED;
        end else if (cur != PL_PINNED) begin
            if (op == CMD_LOCK) nxt = PL_LOCKED;
            else if (op == CMD_OPEN) nxt = PL_OPEN;
        end
        return nxt;
    endfunction

    function automatic logic acc_modifies(acc_op_e op);
        return op != ACC_READ;
    endfunction

endpackage

// File: rtl/lockprot_store.sv
module lockprot_store
    import lockprot_pkg::*;
#(
    parameter int BLOCKS = 8,
    localparam int BW = (BLOCKS > 1) ? $clog2(BLOCKS) : 1
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         cmd_valid,
    input  logic [1:0]                   cmd_op,
    input  logic [BW-1:0]                cmd_blk,
    output prot_lvl_e [BLOCKS-1:0]       lvl_q,
    output prot_lvl_e [BLOCKS-1:0]       lvl_d
);

    cmd_op_e cop;
    logic    is_level_cmd;

    assign cop          = cmd_op_e'(cmd_op);
    assign is_level_cmd = cmd_valid && (cop != CMD_CLR_ERR);

    always_comb begin
        for (int i = 0; i < BLOCKS; i++) begin
            if (is_level_cmd && (cmd_blk == BW'(i)))
                lvl_d[i] = lvl_next(lvl_q[i], cop);
            else
                lvl_d[i] = lvl_q[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < BLOCKS; i++) lvl_q[i] <= PL_LOCKED;
        end else begin
            lvl_q <= lvl_d;
        end
    end

    generate
        for (genvar g = 0; g < BLOCKS; g++) begin : g_chk
            // R1
            reset_lock_chk: assert property (@(posedge clk) disable iff (rst)
                $past(rst) |-> (lvl_q[g] == PL_LOCKED));
            // R2
            enc_legal_chk: assert property (@(posedge clk) disable iff (rst)
                lvl_q[g] != prot_lvl_e'(2'b10));
            // R8
            pin_hold_chk: assert property (@(posedge clk) disable iff (rst)
                (lvl_q[g] == PL_PINNED) |=> (lvl_q[g] == PL_PINNED));
            // R11
            other_blk_chk: assert property (@(posedge clk) disable iff (rst)
                (!cmd_valid || (cmd_blk != BW'(g))) |=> $stable(lvl_q[g]));
        end
    endgenerate

endmodule

// File: rtl/lockprot_gate.sv
module lockprot_gate
    import lockprot_pkg::*;
#(
    parameter int BLOCKS = 8,
    localparam int BW = (BLOCKS > 1) ? $clog2(BLOCKS) : 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   req_valid,
    input  logic [1:0]             req_op,
    input  logic [BW-1:0]          req_blk,
    input  logic                   supply_low,
    input  logic                   clr_err,
    input  prot_lvl_e [BLOCKS-1:0] lvl_d,
    output verdict_t               vrd_q,
    output logic [BW-1:0]          blk_q,
    output logic                   err_q
);

    localparam logic [BW:0] LIMIT = (BW+1)'(BLOCKS);

    acc_op_e   rop;
    prot_lvl_e eff_lvl;
    logic      in_range;
    logic      allow;
    logic      refuse;

    assign rop      = acc_op_e'(req_op);
    assign in_range = {1'b0, req_blk} < LIMIT;

    // Level after any same-cycle command, so updates apply at once
    always_comb begin
        eff_lvl = PL_PINNED;
        if (in_range) eff_lvl = lvl_d[req_blk];
    end

    always_comb begin
        allow = 1'b1;
        if (acc_modifies(rop))
            allow = in_range && !supply_low && (eff_lvl == PL_OPEN);
    end

    assign refuse = req_valid && !allow;

    always_ff @(posedge clk) begin
        if (rst) begin
            vrd_q <= '0;
            blk_q <= '0;
            err_q <= 1'b0;
        end else begin
            vrd_q.valid <= req_valid;
            vrd_q.grant <= req_valid && allow;
            vrd_q.op    <= rop;
            blk_q       <= req_blk;
            if (refuse)       err_q <= 1'b1;
            else if (clr_err) err_q <= 1'b0;
        end
    end

    // R6
    lockout_deny_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && (req_op != 2'b00) && supply_low) |=> (vrd_q.valid && !vrd_q.grant));
    // R7
    read_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && (req_op == 2'b00)) |=> (vrd_q.valid && vrd_q.grant));
    // R5
    closed_deny_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && (req_op != 2'b00) && (eff_lvl != PL_OPEN)) |=> !vrd_q.grant);
    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (err_q && !clr_err) |=> err_q);
    // R9
    deny_flags_chk: assert property (@(posedge clk) disable iff (rst)
        (vrd_q.valid && !vrd_q.grant) |-> err_q);

endmodule

// File: rtl/lockprot_unit.sv
module lockprot_unit
    import lockprot_pkg::*;
#(
    parameter int BLOCKS = 8,
    localparam int BW = (BLOCKS > 1) ? $clog2(BLOCKS) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_valid,
    input  logic [1:0]    cmd_op,
    input  logic [BW-1:0] cmd_blk,
    input  logic          req_valid,
    input  logic [1:0]    req_op,
    input  logic [BW-1:0] req_blk,
    input  logic          supply_low,
    input  logic [BW-1:0] rd_blk,
    output logic [1:0]    rd_state,
    output logic          resp_valid,
    output logic          resp_grant,
    output logic          resp_deny,
    output logic          array_valid,
    output logic [1:0]    array_op,
    output logic [BW-1:0] array_blk,
    output logic          err_locked
);

    localparam logic [BW:0] LIMIT = (BW+1)'(BLOCKS);

    prot_lvl_e [BLOCKS-1:0] lvl_q;
    prot_lvl_e [BLOCKS-1:0] lvl_d;
    verdict_t               vrd_q;
    logic [BW-1:0]          blk_q;
    logic                   err_q;
    logic                   clr_err;

    assign clr_err = cmd_valid && (cmd_op_e'(cmd_op) == CMD_CLR_ERR);

    lockprot_store #(.BLOCKS(BLOCKS)) u_store (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_blk   (cmd_blk),
        .lvl_q     (lvl_q),
        .lvl_d     (lvl_d)
    );

    lockprot_gate #(.BLOCKS(BLOCKS)) u_gate (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_op     (req_op),
        .req_blk    (req_blk),
        .supply_low (supply_low),
        .clr_err    (clr_err),
        .lvl_d      (lvl_d),
        .vrd_q      (vrd_q),
        .blk_q      (blk_q),
        .err_q      (err_q)
    );

    always_comb begin
        rd_state = PL_LOCKED;
        if ({1'b0, rd_blk} < LIMIT) rd_state = lvl_q[rd_blk];
    end

    assign resp_valid  = vrd_q.valid;
    assign resp_grant  = vrd_q.grant;
    assign resp_deny   = vrd_q.valid && !vrd_q.grant;
    assign array_valid = vrd_q.valid && vrd_q.grant;
    assign array_op    = vrd_q.op;
    assign array_blk   = blk_q;
    assign err_locked  = err_q;

    // R10
    forward_only_grant_chk: assert property (@(posedge clk) disable iff (rst)
        array_valid |-> (resp_valid && !resp_deny));

endmodule

// File: tb/lockprot_unit_test.sv
module lockprot_unit_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_op = 2'b00;
    logic [2:0] cmd_blk = 3'd0;
    logic       req_valid = 1'b0;
    logic [1:0] req_op = 2'b00;
    logic [2:0] req_blk = 3'd0;
    logic       supply_low = 1'b0;
    logic [2:0] rd_blk = 3'd0;
    logic [1:0] rd_state;
    logic       resp_valid, resp_grant, resp_deny;
    logic       array_valid;
    logic [1:0] array_op;
    logic [2:0] array_blk;
    logic       err_locked;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic       grant;
        logic [1:0] op;
        logic [2:0] blk;
        logic       err;
        string      tag;
    } exp_t;

    exp_t       sb[$];
    logic [1:0] mdl[8];
    logic       mdl_err;

    always #5 clk = ~clk;

    lockprot_unit #(.BLOCKS(8)) uut (
        .clk(clk), .rst(rst),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_blk(cmd_blk),
        .req_valid(req_valid), .req_op(req_op), .req_blk(req_blk),
        .supply_low(supply_low), .rd_blk(rd_blk), .rd_state(rd_state),
        .resp_valid(resp_valid), .resp_grant(resp_grant), .resp_deny(resp_deny),
        .array_valid(array_valid), .array_op(array_op), .array_blk(array_blk),
        .err_locked(err_locked)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [1:0] mdl_next(logic [1:0] cur, logic [1:0] op);
        if (op == 2'b11) return 2'b11;
        if (cur == 2'b11) return 2'b11;
        if (op == 2'b01) return 2'b01;
        if (op == 2'b10) return 2'b00;
        return cur;
    endfunction

    // Driver: one cycle of stimulus, expected verdict pushed to the scoreboard
    task automatic step(input logic cv, input logic [1:0] co, input logic [2:0] cb,
                        input logic rv, input logic [1:0] ro, input logic [2:0] rb,
                        input logic sl, input string tag);
        logic clr = 1'b0;
        logic g = 1'b1;
        exp_t e;
        @(negedge clk);
        cmd_valid = cv; cmd_op = co; cmd_blk = cb;
        req_valid = rv; req_op = ro; req_blk = rb;
        supply_low = sl;
        if (cv) begin
            if (co == 2'b00) clr = 1'b1;
            else mdl[cb] = mdl_next(mdl[cb], co);
        end
        if (rv && ro != 2'b00) g = !sl && (mdl[rb] == 2'b00);
        if (rv && !g) mdl_err = 1'b1;
        else if (clr) mdl_err = 1'b0;
        if (rv) begin
            e.grant = g; e.op = ro; e.blk = rb; e.err = mdl_err; e.tag = tag;
            sb.push_back(e);
        end
        @(posedge clk);
        #1;
        cmd_valid = 1'b0; req_valid = 1'b0; supply_low = 1'b0;
    endtask

    task automatic check_rd(input logic [2:0] b, input string tag);
        @(negedge clk);
        rd_blk = b;
        #1;
        chk(tag, {6'd0, rd_state}, {6'd0, mdl[b]});
    endtask

    task automatic check_err(input string tag);
        @(negedge clk);
        chk(tag, {7'd0, err_locked}, {7'd0, mdl_err});
    endtask

    // Monitor: compares each verdict as it appears
    always @(posedge clk) begin
        #2;
        if (!rst && resp_valid) begin
            if (sb.size() == 0) begin
                chk("R5 unexpected response", 8'd1, 8'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk({e.tag, " grant"}, {7'd0, resp_grant}, {7'd0, e.grant});
                chk({e.tag, " deny"}, {7'd0, resp_deny}, {7'd0, !e.grant});
                chk({e.tag, " R10 array_valid"}, {7'd0, array_valid}, {7'd0, e.grant});
                if (e.grant) begin
                    chk({e.tag, " R10 array_op"}, {6'd0, array_op}, {6'd0, e.op});
                    chk({e.tag, " R10 array_blk"}, {5'd0, array_blk}, {5'd0, e.blk});
                end
                chk({e.tag, " R9 err"}, {7'd0, err_locked}, {7'd0, e.err});
            end
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        for (int i = 0; i < 8; i++) mdl[i] = 2'b01;
        mdl_err = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: actual running expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset state
        for (int b = 0; b < 8; b++) check_rd(3'(b), "R1 reset level");
        check_err("R1 reset err");
        @(negedge clk);
        chk("R1 no response", {7'd0, resp_valid}, 8'd0);

        // R5 locked block denies, R9 sets flag, clear command clears it
        step(0, 2'b00, 0, 1, 2'b01, 3'd2, 0, "R5 program locked");
        step(0, 2'b00, 0, 1, 2'b11, 3'd6, 0, "R5 op11 locked");
        check_err("R9 sticky set");
        step(1, 2'b00, 0, 0, 2'b00, 0, 0, "R9 clear");
        check_err("R9 cleared");

        // R3 open, R11 neighbour untouched
        step(1, 2'b10, 3'd2, 0, 2'b00, 0, 0, "R3 open");
        check_rd(3'd2, "R3 open readback");
        check_rd(3'd3, "R11 neighbour");
        step(0, 2'b00, 0, 1, 2'b01, 3'd2, 0, "R5 program open");
        step(0, 2'b00, 0, 1, 2'b10, 3'd2, 0, "R5 erase open");
        step(0, 2'b00, 0, 1, 2'b10, 3'd3, 0, "R11 erase neighbour");
        step(1, 2'b00, 0, 0, 2'b00, 0, 0, "R9 clear");

        // R4 same-cycle bypass both ways
        step(1, 2'b01, 3'd2, 1, 2'b10, 3'd2, 0, "R4 lock+erase");
        check_rd(3'd2, "R3 lock readback");
        step(1, 2'b10, 3'd2, 1, 2'b10, 3'd2, 0, "R4 open+erase");

        // R6 supply lockout, R7 reads
        step(0, 2'b00, 0, 1, 2'b01, 3'd2, 1, "R6 lockout program");
        step(0, 2'b00, 0, 1, 2'b00, 3'd2, 1, "R7 read under lockout");
        step(0, 2'b00, 0, 1, 2'b00, 3'd5, 0, "R7 read locked");

        // R9 set wins over clear in the same cycle, then clear with a grant
        step(1, 2'b00, 0, 1, 2'b01, 3'd5, 0, "R9 deny+clear");
        step(1, 2'b00, 0, 1, 2'b00, 3'd5, 0, "R9 grant+clear");

        // R8 pinning from locked and from open
        step(1, 2'b11, 3'd4, 0, 2'b00, 0, 0, "R8 pin locked");
        check_rd(3'd4, "R8 pinned readback");
        step(1, 2'b10, 3'd4, 0, 2'b00, 0, 0, "R8 open ignored");
        check_rd(3'd4, "R8 open ignored readback");
        step(1, 2'b10, 3'd4, 1, 2'b10, 3'd4, 0, "R8 open+erase pinned");
        step(1, 2'b01, 3'd4, 0, 2'b00, 0, 0, "R8 lock ignored");
        check_rd(3'd4, "R8 lock ignored readback");
        step(1, 2'b11, 3'd2, 0, 2'b00, 0, 0, "R8 pin open");
        check_rd(3'd2, "R8 pin from open readback");
        step(0, 2'b00, 0, 1, 2'b01, 3'd2, 0, "R8 program pinned");
        check_rd(3'd1, "R11 block1 untouched");

        // R1 reset leaves pinned
        @(negedge clk);
        repeat (2) @(posedge clk);
        do_reset();
        check_rd(3'd4, "R1 pin cleared by reset");
        check_rd(3'd2, "R1 pin cleared by reset");
        check_err("R1 err after reset");

        repeat (3) @(posedge clk);
        #3;
        chk("R5 all responses seen", 8'(sb.size()), 8'd0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule